// File: doc/BRIEF.md
# Pulse-TDM Source and Demodulation Sequencer

This block produces the timing for a four-source, time-division multiplexed optical measurement. A fast reference clock is divided down to a slot period chosen by a static select input. Each frame holds eight equal slots. Every source owns one slot in which its laser gate may fire, and the slot after it is dark: all sources are off, so the detector reference for that source can be taken. Each source is therefore lit for one slot in eight, and no two sources are ever lit together.

The same slot counter drives an eight-wide one-hot bin-select bus. An external analog demultiplexer uses it to steer the detector signal into the averaging bin for the current slot (signal bin, then reference bin, for each source). At the start of every slot a settling window, a selectable fraction of the slot, holds `bin_valid` low while the bin-select already shows the new slot. Per-laser enable bits mask the gates without touching the slot timing. A one-cycle `frame_start` marks the first cycle of slot 0. Laser timing and bin steering come from one counter, so they cannot drift apart in phase.

Top module: `ptdm_sequencer`

## Requirements
- R1: A frame has eight slots of L cycles each and repeats without gaps; during slot k (0..7) `bin_sel` is one-hot with only bit k set.
- R2: `laser_gate[i]` may be high only during slot 2i; slots 1, 3, 5 and 7 have all gates low, so at most one gate is high in any cycle.
- R3: `laser_gate[i]` is high in slot 2i exactly when `laser_en[i]` is 1; changing `laser_en` does not change slot timing, `bin_sel` or `bin_valid`.
- R4: The slot length is L = 2^(div_sel+1) reference cycles for `div_sel` 0 to 14; `div_sel` 15 gives L = 2^15.
- R5: `bin_valid` is low for the first floor(settle_sel*L/16) cycles of every slot and high for the rest of the slot (`settle_sel` 0 gives no blanking).
- R6: `frame_start` is high for exactly one cycle, the first cycle of slot 0, and low otherwise.
- R7: Reset is synchronous and active high: while `rst` is high all gates, `bin_valid` and `frame_start` are low; the first cycle after `rst` falls is cycle 0 of slot 0.
- R8: If `div_sel` is changed so that the current position in the slot is already at or past the new L-1, the slot ends at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| div_sel | input | 4 | Slot length select, L = 2^(div_sel+1), clamped at 2^15 |
| settle_sel | input | 2 | Settling window in sixteenths of a slot (0 to 3) |
| laser_en | input | 4 | Per-laser gate enable, bit i for source i |
| laser_gate | output | 4 | Laser gate, bit i lit in slot 2i when enabled |
| bin_sel | output | 8 | One-hot averaging bin select, bit k in slot k |
| bin_valid | output | 1 | Low during the settling window at the start of each slot |
| frame_start | output | 1 | One-cycle pulse on the first cycle of slot 0 |

## Verification
The frame marker and the settling blanking both fall on the first cycle of slot 0, and a source gate is lit in that same cycle while the bin is still blanked. The bench provokes this with settling codes from 0 to 3 across several slot lengths, including lengths where the window rounds to zero, and judges every cycle against a model that counts slot position from the requirements. A mid-slot change of the divide select is also made so that a slot end and a shortened length meet in one edge.

// File: rtl/ptdm_pkg.sv
package ptdm_pkg;
  // Largest slot length is 2^MAX_LOG reference cycles.
  localparam int MAX_LOG = 15;
  localparam int PH_W    = MAX_LOG;
  localparam int SEL_W   = 4;
  localparam int SET_W   = 2;

  typedef logic [PH_W-1:0] phase_t;
  typedef logic [PH_W:0]   len_t;

  // Slot length in reference cycles: 2^(sel+1), clamped at 2^MAX_LOG.
  function automatic len_t slot_len(input logic [SEL_W-1:0] sel);
    int unsigned e;
    e = int'(sel) + 1;
    if (e > MAX_LOG) e = MAX_LOG;
    return len_t'(1) << e;
  endfunction

  // Settling window: code sixteenths of a slot, rounded down.
  function automatic phase_t settle_len(input logic [SET_W-1:0] code,
                                        input logic [SEL_W-1:0] sel);
    logic [PH_W+2:0] prod;
    prod = {2'b00, slot_len(sel)} * {{(PH_W+1){1'b0}}, code};
    return {1'b0, prod[PH_W+2:4]};
  endfunction
endpackage

// File: rtl/ptdm_prescaler.sv
module ptdm_prescaler
  import ptdm_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] div_sel,
  output phase_t           phase,
  output logic             slot_end
);
  len_t   limit;
  phase_t phase_q;

  assign limit    = slot_len(div_sel) - len_t'(1);
  // Greater-or-equal lets a shortened slot close at once.
  assign slot_end = ({1'b0, phase_q} >= limit);
  assign phase    = phase_q;

  always_ff @(posedge clk) begin
    if (rst)           phase_q <= '0;
    else if (slot_end) phase_q <= '0;
    else               phase_q <= phase_q + phase_t'(1);
  end

  AST_PHASE_STEP: assert property (@(posedge clk) disable iff (rst)
    !slot_end |=> phase == $past(phase) + phase_t'(1)); // R4

  AST_PHASE_WRAP: assert property (@(posedge clk) disable iff (rst)
    slot_end |=> phase == '0); // R8
endmodule

// File: rtl/ptdm_slot_counter.sv
module ptdm_slot_counter #(
  parameter int N_SLOT = 8,
  localparam int SLOT_W = $clog2(N_SLOT)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              slot_end,
  output logic [SLOT_W-1:0] slot
);
  logic [SLOT_W-1:0] slot_q;
  logic              last_slot;

  assign last_slot = (slot_q == SLOT_W'(N_SLOT - 1));
  assign slot      = slot_q;

  always_ff @(posedge clk) begin
    if (rst)                        slot_q <= '0;
    else if (slot_end && last_slot) slot_q <= '0;
    else if (slot_end)              slot_q <= slot_q + SLOT_W'(1);
  end

  AST_SLOT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !slot_end |=> $stable(slot)); // R1

  AST_SLOT_WRAP: assert property (@(posedge clk) disable iff (rst)
    (slot_end && last_slot) |=> slot == '0); // R1
endmodule

// File: rtl/ptdm_slot_decode.sv
module ptdm_slot_decode
  import ptdm_pkg::*;
#(
  parameter int NUM_SRC = 4,
  localparam int N_BIN  = 2 * NUM_SRC,
  localparam int SLOT_W = $clog2(N_BIN)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [SLOT_W-1:0]  slot,
  input  phase_t             phase,
  input  phase_t             settle,
  input  logic [NUM_SRC-1:0] laser_en,
  output logic [NUM_SRC-1:0] laser_gate,
  output logic [N_BIN-1:0]   bin_sel,
  output logic               bin_valid,
  output logic               frame_start
);
  genvar k;
  generate
    for (k = 0; k < N_BIN; k++) begin : g_bin
      assign bin_sel[k] = (slot == SLOT_W'(k));
    end
    for (k = 0; k < NUM_SRC; k++) begin : g_gate
      // Source k lights only in its even slot; the odd slot after it is dark.
      assign laser_gate[k] = !rst && laser_en[k] && (slot == SLOT_W'(2 * k));
    end
  endgenerate

  assign bin_valid   = !rst && (phase >= settle);
  assign frame_start = !rst && (slot == '0) && (phase == '0);

  AST_ONE_GATE: assert property (@(posedge clk) disable iff (rst)
    $onehot0(laser_gate)); // R2

  AST_BIN_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $countones(bin_sel) == 1); // R1

  AST_FRAME_BLANK: assert property (@(posedge clk) disable iff (rst)
    (frame_start && settle != '0) |-> !bin_valid); // R5

  AST_FRAME_SINGLE: assert property (@(posedge clk) disable iff (rst)
    frame_start |=> !frame_start); // R6
endmodule

// File: rtl/ptdm_sequencer.sv
module ptdm_sequencer
  import ptdm_pkg::*;
#(
  parameter int NUM_SRC = 4,
  localparam int N_BIN  = 2 * NUM_SRC,
  localparam int SLOT_W = $clog2(N_BIN)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [SEL_W-1:0]   div_sel,
  input  logic [SET_W-1:0]   settle_sel,
  input  logic [NUM_SRC-1:0] laser_en,
  output logic [NUM_SRC-1:0] laser_gate,
  output logic [N_BIN-1:0]   bin_sel,
  output logic               bin_valid,
  output logic               frame_start
);
  phase_t            phase;
  phase_t            settle;
  logic              slot_end;
  logic [SLOT_W-1:0] slot;

  assign settle = settle_len(settle_sel, div_sel);

  ptdm_prescaler u_prescaler (
    .clk      (clk),
    .rst      (rst),
    .div_sel  (div_sel),
    .phase    (phase),
    .slot_end (slot_end)
  );

  ptdm_slot_counter #(.N_SLOT(N_BIN)) u_slot_counter (
    .clk      (clk),
    .rst      (rst),
    .slot_end (slot_end),
    .slot     (slot)
  );

  ptdm_slot_decode #(.NUM_SRC(NUM_SRC)) u_decode (
    .clk         (clk),
    .rst         (rst),
    .slot        (slot),
    .phase       (phase),
    .settle      (settle),
    .laser_en    (laser_en),
    .laser_gate  (laser_gate),
    .bin_sel     (bin_sel),
    .bin_valid   (bin_valid),
    .frame_start (frame_start)
  );

  AST_RESTART_FRAME: assert property (@(posedge clk)
    $fell(rst) |-> frame_start); // R7
endmodule

// File: tb/ptdm_sequencer_bench.sv
module ptdm_sequencer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 4;
  localparam int NB = 2 * NS;
  // Vector fields: [26:23] div_sel, [22:21] settle_sel, [20:17] laser_en, [16:0] cycles.
  localparam logic [26:0] VEC [7] = '{
    {4'd0,  2'd0, 4'hF, 17'd40},
    {4'd1,  2'd3, 4'hF, 17'd80},
    {4'd3,  2'd2, 4'hA, 17'd300},
    {4'd4,  2'd3, 4'h5, 17'd600},
    {4'd5,  2'd1, 4'hF, 17'd1200},
    {4'd15, 2'd2, 4'hF, 17'd66000},
    {4'd14, 2'd1, 4'h3, 17'd1000}
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [3:0]    div_sel = '0;
  logic [1:0]    settle_sel = '0;
  logic [NS-1:0] laser_en = '1;
  logic [NS-1:0] laser_gate;
  logic [NB-1:0] bin_sel;
  logic          bin_valid;
  logic          frame_start;

  int checks = 0;
  int failures = 0;
  int ph = 0;
  int sl = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ptdm_sequencer u_ptdm_sequencer (
    .clk(clk), .rst(rst), .div_sel(div_sel), .settle_sel(settle_sel),
    .laser_en(laser_en), .laser_gate(laser_gate), .bin_sel(bin_sel),
    .bin_valid(bin_valid), .frame_start(frame_start)
  );

  function automatic int len_of(int d);
    return (d >= 14) ? 32768 : (2 << d);
  endfunction

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h (slot %0d pos %0d)", req, what, act, exp, sl, ph);
    end
  endtask

  // One cycle: compare outputs against the model, then advance the model at the edge.
  task automatic cyc(string tag);
    int len;
    int st;
    logic [NS-1:0] eg;
    logic [NB-1:0] eb;
    #1;
    len = len_of(int'(div_sel));
    st  = int'(settle_sel) * len / 16;
    for (int i = 0; i < NS; i++) eg[i] = !rst && laser_en[i] && (sl == 2 * i);
    eb = '0;
    eb[sl] = 1'b1;
    check(laser_gate === eg, {"R2 R3 ", tag}, "laser_gate", laser_gate, eg);
    check(bin_sel === eb, {"R1 ", tag}, "bin_sel", bin_sel, eb);
    check(bin_valid === (!rst && ph >= st), {"R5 ", tag}, "bin_valid", bin_valid, (!rst && ph >= st));
    check(frame_start === (!rst && sl == 0 && ph == 0), {"R6 ", tag}, "frame_start",
          frame_start, (!rst && sl == 0 && ph == 0));
    @(posedge clk);
    if (rst) begin ph = 0; sl = 0; end
    else if (ph >= len - 1) begin ph = 0; sl = (sl + 1) % NB; end
    else ph++;
    @(negedge clk);
  endtask

  initial begin
    repeat (2) @(posedge clk);
    @(negedge clk);
    cyc("R7 reset hold");
    // Table walk: every divide range, settle code and mask pattern.
    for (int v = 0; v < 7; v++) begin
      rst = 1'b1;
      div_sel    = VEC[v][26:23];
      settle_sel = VEC[v][22:21];
      laser_en   = VEC[v][20:17];
      cyc("R7 reset");
      cyc("R7 reset");
      rst = 1'b0;
      for (int n = 0; n < int'(VEC[v][16:0]); n++) cyc("R4 vector");
    end
    // R8: shorten the slot while the position is beyond the new end.
    rst = 1'b1; div_sel = 4'd5; settle_sel = 2'd1; laser_en = 4'hF;
    cyc("R7 reset");
    rst = 1'b0;
    repeat (50) cyc("R8 before");
    div_sel = 4'd2;
    repeat (100) cyc("R8 after");
    // R3: mask changes mid-slot leave timing untouched.
    rst = 1'b1; div_sel = 4'd3; settle_sel = 2'd3;
    cyc("R7 reset");
    rst = 1'b0;
    repeat (5) cyc("R3 lit");
    laser_en = 4'b1110;
    repeat (20) cyc("R3 masked");
    laser_en = 4'b0000;
    repeat (60) cyc("R3 all masked");
    laser_en = 4'hF;
    repeat (200) cyc("R3 restored");
    // R7: reset in the middle of a frame restarts at slot 0.
    rst = 1'b1;
    cyc("R7 mid reset");
    cyc("R7 mid reset");
    rst = 1'b0;
    repeat (300) cyc("R7 restart");
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule